// File: doc/BRIEF.md
# Double-Data-Rate I/Q Sample Splitter

This block sits behind the pins of a dual-channel converter interface. A single parallel bus carries in-phase (I) and quadrature (Q) samples that take turns, one word on every edge of the data clock, so one clock period moves one I/Q pair. The block captures a word on the falling edge and a word on the rising edge. It then brings both into a rising-edge pipeline and presents each completed pair on two separate parallel outputs, together with a one-cycle valid strobe.

Three run-time control inputs decide how the stream is read. `iRising` selects the edge whose word is I; the word on the other edge is Q. `iFirst` selects whether I or Q opens a pair. Together these two give four pairing modes. `twosIn` states whether the incoming words are twos complement or unsigned offset binary. The outputs are always twos complement. After a reset or a control change, pairing restarts from clean state. A half pair left over from the old settings never reaches the outputs.

The bus width is a parameter with a default of 10 bits. The intended widths are 8, 10, 12 and 14 bits.

Top module: `iq_ddr_deinterleaver`

## Requirements
- R1: While `rstN` is low, `outValid` is low, and it stays low on the first two rising edges after reset is released.
- R2: With the control inputs held steady, once the first pair has been presented, `outValid` is high on every clock cycle: one pair per clock period.
- R3: With `iFirst`=1 and `iRising`=1, a pair opens with the rising-edge word, which is I, and the next falling-edge word is its Q.
- R4: With `iFirst`=0 and `iRising`=1, a pair opens with the falling-edge word, which is Q, and the next rising-edge word is its I.
- R5: With `iFirst`=1 and `iRising`=0, a pair opens with the falling-edge word, which is I, and the next rising-edge word is its Q.
- R6: With `iFirst`=0 and `iRising`=0, a pair opens with the rising-edge word, which is Q, and the next falling-edge word is its I.
- R7: With `twosIn`=1, words pass to `outI`/`outQ` unchanged. With `twosIn`=0, bit DATA_W-1 of each word is inverted, which turns offset binary into twos complement.
- R8: Latency depends on the edge that closes the pair. If the closing word is captured on a rising edge, the pair appears after the next rising edge. If it is captured on a falling edge, the pair appears after the second rising edge that follows.
- R9: The control inputs are sampled on rising edges. On an edge where they differ from the previous edge, `outValid` goes low on that edge and on the next one. Pairing restarts with the word captured on that same edge, and no word captured before it is ever paired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; both edges capture a word |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | DATA_W | Shared I/Q data bus |
| iFirst | input | 1 | 1: I opens each pair; 0: Q opens each pair |
| iRising | input | 1 | 1: I is captured on the rising edge; 0: on the falling edge |
| twosIn | input | 1 | 1: input is twos complement; 0: offset binary |
| outValid | output | 1 | High for one cycle per presented pair |
| outI | output | DATA_W | I sample, twos complement |
| outQ | output | DATA_W | Q sample, twos complement |

## Verification
The state that matters lives in three places: the pairing phase, the priming flag and the registered mode. If the pairing phase is wrong, every pair is off by one word, so I carries a word from the neighbouring pair or I and Q are swapped. This shows up on the first valid cycle after priming, two rising edges after reset or a control change. If the priming flag is wrong, the outputs carry a stale half pair, or a valid pulse is missing, in the window right after a control change. If the latency is wrong, the outputs differ from the reference model on every cycle of a counting-free random stream. The bench therefore exercises all four modes, both formats, extreme words (all zeros, all ones, sign bit alone, largest positive), back-to-back control changes and a reset in the middle of the stream.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;

  // Per-cycle strobes from the control unit to the datapath.
  typedef struct packed {
    logic emit;       // present the pair held in the staging registers
    logic riseFirst;  // the pair opens on a rising-edge word
    logic iOnRise;    // the I word is the rising-edge word of the pair
    logic twos;       // input already twos complement
  } pairStrobe_t;

endpackage

// File: rtl/iq_deint_ctrl.sv
module iq_deint_ctrl
  import iq_deint_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        iFirst,
  input  logic        iRising,
  input  logic        twosIn,
  output pairStrobe_t strobe
);

  localparam int MODE_W = 3;

  logic [MODE_W-1:0] modeNow;
  logic [MODE_W-1:0] modeQ;
  logic              armed;
  logic              primed;
  logic              clearPair;

  assign modeNow = {iFirst, iRising, twosIn};

  // The first edge out of reset, or any change of settings, restarts pairing.
  assign clearPair = !armed || (modeNow != modeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      armed  <= 1'b0;
      primed <= 1'b0;
    end else begin
      modeQ  <= modeNow;
      armed  <= 1'b1;
      primed <= !clearPair;
    end
  end

  always_comb begin
    strobe.emit      = primed && !clearPair;
    strobe.riseFirst = (modeQ[2] == modeQ[1]);
    strobe.iOnRise   = modeQ[1];
    strobe.twos      = modeQ[0];
  end

endmodule

// File: rtl/iq_deint_datapath.sv
module iq_deint_datapath
  import iq_deint_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  pairStrobe_t       strobe,
  output logic              outValid,
  output logic [DATA_W-1:0] outI,
  output logic [DATA_W-1:0] outQ
);

  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] fallCap;     // word captured on the falling edge
  logic [DATA_W-1:0] stRise;      // rising-edge word of this edge
  logic [DATA_W-1:0] stRisePrev;  // rising-edge word of the previous edge
  logic [DATA_W-1:0] stFall;      // falling-edge word between them
  logic [DATA_W-1:0] riseWord;
  logic [DATA_W-1:0] fallWord;
  logic [DATA_W-1:0] fmtMask;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallCap <= '0;
    else       fallCap <= busIn;
  end

  // Single-edge staging: holds rise(k-1), fall(k-1), rise(k).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stRise     <= '0;
      stRisePrev <= '0;
      stFall     <= '0;
    end else begin
      stRise     <= busIn;
      stRisePrev <= stRise;
      stFall     <= fallCap;
    end
  end

  always_comb begin
    riseWord = strobe.riseFirst ? stRisePrev : stRise;
    fallWord = stFall;
    fmtMask  = strobe.twos ? '0 : SIGN_FLIP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outI <= (strobe.iOnRise ? riseWord : fallWord) ^ fmtMask;
        outQ <= (strobe.iOnRise ? fallWord : riseWord) ^ fmtMask;
      end
    end
  end

endmodule

// File: rtl/iq_ddr_deinterleaver.sv
module iq_ddr_deinterleaver #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  logic              iFirst,
  input  logic              iRising,
  input  logic              twosIn,
  output logic              outValid,
  output logic [DATA_W-1:0] outI,
  output logic [DATA_W-1:0] outQ
);

  iq_deint_pkg::pairStrobe_t strobe;

  iq_deint_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .iFirst  (iFirst),
    .iRising (iRising),
    .twosIn  (twosIn),
    .strobe  (strobe)
  );

  iq_deint_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busIn    (busIn),
    .strobe   (strobe),
    .outValid (outValid),
    .outI     (outI),
    .outQ     (outQ)
  );

endmodule

// File: rtl/iq_deint_checker.sv
module iq_deint_checker #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busIn,
  input logic              iFirst,
  input logic              iRising,
  input logic              twosIn,
  input logic              outValid,
  input logic [DATA_W-1:0] outI,
  input logic [DATA_W-1:0] outQ
);

  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [2:0] ctrlBits;
  assign ctrlBits = {iFirst, iRising, twosIn};

  // R1: no pair is presented while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rstN |-> !outValid);

  // R9: a settings change blanks the strobe on that edge and the next
  a_r9_change_blanks: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits != $past(ctrlBits)) |=> !outValid ##1 !outValid);

  // R2: with steady settings the stream keeps one pair per cycle
  a_r2_continuous: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $stable(ctrlBits) |=> outValid);

  // R3 R7: I-first on rising edge, I is the rising word three edges back
  a_r3_i_rise_first: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(iFirst) && $past(iRising) |->
      outI == ($past(busIn, 3) ^ ($past(twosIn) ? '0 : SIGN_FLIP)));

  // R4 R7: Q-first, I rides the closing rising edge two edges back
  a_r4_i_rise_second: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(iFirst) && $past(iRising) |->
      outI == ($past(busIn, 2) ^ ($past(twosIn) ? '0 : SIGN_FLIP)));

  // R5 R7: I-first on falling edge, Q is the closing rising word
  a_r5_q_rise_second: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(iFirst) && !$past(iRising) |->
      outQ == ($past(busIn, 2) ^ ($past(twosIn) ? '0 : SIGN_FLIP)));

endmodule

bind iq_ddr_deinterleaver iq_deint_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busIn    (busIn),
  .iFirst   (iFirst),
  .iRising  (iRising),
  .twosIn   (twosIn),
  .outValid (outValid),
  .outI     (outI),
  .outQ     (outQ)
);

// File: tb/test_iq_ddr_deinterleaver.sv
module test_iq_ddr_deinterleaver;

  localparam int DATA_W     = 10;
  localparam int CLK_PERIOD = 10;
  localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] busIn = '0;
  logic              iFirst = 1'b1;
  logic              iRising = 1'b1;
  logic              twosIn = 1'b1;
  logic              outValid;
  logic [DATA_W-1:0] outI;
  logic [DATA_W-1:0] outQ;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  iq_ddr_deinterleaver #(.DATA_W(DATA_W)) i_iq_ddr_deinterleaver (
    .clk(clk), .rstN(rstN), .busIn(busIn), .iFirst(iFirst),
    .iRising(iRising), .twosIn(twosIn), .outValid(outValid),
    .outI(outI), .outQ(outQ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- stimulus words ----------------
  int wordIdx = 0;
  function automatic logic [DATA_W-1:0] nextWord(int idx);
    case (idx % 23)
      0:       return '0;
      5:       return '1;
      11:      return SIGN_BIT;
      17:      return ~SIGN_BIT;
      default: return DATA_W'($urandom);
    endcase
  endfunction

  // A word driven just after an edge is captured on the opposite edge.
  initial begin
    forever begin
      @(posedge clk); #1; busIn = nextWord(wordIdx); wordIdx++;
      @(negedge clk); #1; busIn = nextWord(wordIdx); wordIdx++;
    end
  end

  // ---------------- behavioural reference ----------------
  logic [DATA_W-1:0] qI[$];
  logic [DATA_W-1:0] qQ[$];
  int                qDue[$];
  string             qTag[$];
  bit                armed = 0;
  bit [2:0]          lastCtrl;
  bit                mRiseFirst, mIOnRise, mTwos;
  bit                havePend = 0;
  logic [DATA_W-1:0] pendWord;
  bit                expValid = 0;
  logic [DATA_W-1:0] expI, expQ;
  string             expTag;

  function automatic string modeTag(bit f, bit r);
    case ({f, r})
      2'b11:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic flushModel();
    qI.delete(); qQ.delete(); qDue.delete(); qTag.delete();
    havePend = 0;
  endtask

  task automatic takeWord(bit isRise, logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] rw, fw, iw, qw;
    if (!armed) return;
    if (!havePend) begin
      if (isRise == mRiseFirst) begin
        pendWord = v;
        havePend = 1;
      end
    end else begin
      rw = isRise ? v : pendWord;
      fw = isRise ? pendWord : v;
      iw = mIOnRise ? rw : fw;
      qw = mIOnRise ? fw : rw;
      if (!mTwos) begin iw = iw ^ SIGN_BIT; qw = qw ^ SIGN_BIT; end
      qI.push_back(iw); qQ.push_back(qw);
      qDue.push_back(isRise ? 1 : 2);  // R8 latency rule
      qTag.push_back(modeTag(lastCtrl[2], lastCtrl[1]));
      havePend = 0;
    end
  endtask

  always @(posedge clk) begin
    expValid = 0;
    if (!rstN) begin
      armed = 0;
      flushModel();
    end else begin
      if (!armed || {iFirst, iRising, twosIn} != lastCtrl) begin
        flushModel();  // R9 restart
        lastCtrl   = {iFirst, iRising, twosIn};
        mRiseFirst = (iFirst == iRising);
        mIOnRise   = iRising;
        mTwos      = twosIn;
        armed      = 1;
      end else begin
        foreach (qDue[n]) qDue[n] = qDue[n] - 1;
        if (qDue.size() > 0 && qDue[0] == 0) begin
          expValid = 1;
          expI = qI.pop_front(); expQ = qQ.pop_front();
          expTag = qTag.pop_front(); void'(qDue.pop_front());
        end
      end
      takeWord(1'b1, busIn);
    end
  end

  always @(negedge clk) begin
    if (rstN) takeWord(1'b0, busIn);
  end

  // ---------------- comparison, every clock ----------------
  always @(posedge clk) begin
    #3;
    if (!finished) begin
      if (!rstN) begin
        total++;
        if (outValid !== 1'b0) begin
          bad++;
          $display("FAIL R1 outValid in reset: actual=%0b expected=0", outValid);
        end
      end else begin
        total++;
        if (outValid !== expValid) begin
          bad++;
          $display("FAIL R2 R8 R9 outValid: actual=%0b expected=%0b", outValid, expValid);
        end else if (expValid) begin
          total++;
          if (outI !== expI || outQ !== expQ) begin
            bad++;
            $display("FAIL %s R7 pair: actual I=%h Q=%h expected I=%h Q=%h",
                     expTag, outI, outQ, expI, expQ);
          end
        end
      end
    end
  end

  // ---------------- sequence ----------------
  task automatic setMode(bit f, bit r, bit t);
    @(posedge clk); #1;
    iFirst = f; iRising = r; twosIn = t;
  endtask

  task automatic runCycles(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    runCycles(3);                 // R1 held in reset
    @(posedge clk); #1 rstN = 1'b1;
    runCycles(40);                // R3 twos complement
    setMode(1, 1, 0); runCycles(40);  // R3 R7 offset binary
    setMode(0, 1, 0); runCycles(40);  // R4
    setMode(1, 0, 1); runCycles(40);  // R5
    setMode(0, 0, 1); runCycles(40);  // R6
    setMode(0, 0, 0); runCycles(30);  // R6 R7
    setMode(1, 0, 0); setMode(0, 1, 1); runCycles(30);  // R9 back to back
    setMode(1, 1, 1); runCycles(1); setMode(0, 0, 1); runCycles(30);
    @(posedge clk); #1 rstN = 1'b0;   // R1 mid-stream reset
    runCycles(2);
    @(posedge clk); #1 rstN = 1'b1;
    runCycles(30);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule